// File: doc/BRIEF.md
# Oscillator Settling Wait Timer

When an oscillator starts, its output needs time to settle. This block holds back the system clock grant until that time has passed. Two events start a wait. The first is a wake request, sent when the system leaves a low-power state for a running state. The second is a switch request, sent when software moves the system clock from the internal RC oscillator to the external oscillator.

A three-bit length code, held in a small register, sets the wait length. Code n stands for N = 2^(n+3) counted cycles. A wake counts cycles of the target oscillator at full rate. A switch counts the RC oscillator after a power-of-two prescaler. That prescaler runs freely, so a switch wait falls somewhere between N and 2N prescaled periods.

Each oscillator cycle reaches the block as a one-cycle enable pulse on the system clock. At the end of a wait the block raises a one-cycle done pulse, and then holds a level grant that lets the clocks through.

Top module: `osc_settle_timer`

## Requirements
- R1: The length code register resets to 0. A cycle with `sel_we` high loads `sel_wdata`, and `sel_q` shows the value from the next cycle on. Each request captures the code, and code n gives N = 2^(n+3).
- R2: After a wake request, `done` is high in the cycle after the clock edge that samples the N-th counted enable pulse. Only edges strictly after the request edge count, so a pulse present on the request edge does not count.
- R3: A wake counts `ext_ce` when `tgt_ext` was 1 at the request, and `rc_ce` when it was 0. Pulses on the other enable have no effect on when `done` rises.
- R4: The timing of a wake does not depend on `div_sel`.
- R5: After a switch request, the block counts `rc_ce` divided by D = 2^`div_sel`. The number W of `rc_ce` pulses sampled after the request edge, up to and including the edge that ends the wait, satisfies N*D <= W <= 2*N*D.
- R6: A switch request samples `div_sel`, and that value sets D for the whole wait. Later changes to `div_sel` do not change D.
- R7: `done` is high for exactly one cycle. `clk_grant` rises in the next cycle and stays high until a request or `stby_entry` is sampled.
- R8: A wake or switch request made during a wait drops the wait in progress and starts a new one. Only the new wait produces `done`.
- R9: `stby_entry` clears `clk_grant` in the next cycle and drops any wait in progress without a `done`.
- R10: Out of reset, `done` and `clk_grant` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_we | input | 1 | Write strobe for the length code register |
| sel_wdata | input | 3 | Value to write to the length code register |
| sel_q | output | 3 | Current length code |
| ext_ce | input | 1 | One pulse per external oscillator cycle |
| rc_ce | input | 1 | One pulse per RC oscillator cycle |
| tgt_ext | input | 1 | Clock source after a wake: 1 = external, 0 = RC |
| wake_req | input | 1 | One-cycle request to start a wake wait |
| switch_req | input | 1 | One-cycle request to start an RC-to-external switch wait |
| stby_entry | input | 1 | One-cycle pulse when the system enters standby |
| div_sel | input | 3 | Prescaler exponent used for switch waits |
| done | output | 1 | One-cycle pulse when a wait ends |
| clk_grant | output | 1 | Level grant for the system clocks |

## Verification
Each wake is run with the wrong enable held high on every cycle and the right enable pulsing every other cycle. A design that counts the wrong source therefore finishes about twice too early. Each wake also places a right-source pulse on the request edge, which catches an off-by-one at the start, and one wake runs with the largest `div_sel` to show that the divider is ignored. Switch waits run with `rc_ce` high on every cycle at several `div_sel` values, and each `done` is checked against the N*D to 2N*D window. In one of them `div_sel` is raised early in the wait, so a design that does not hold the divider finishes too late. Restart and standby-abort sequences show that an abandoned wait never produces `done`.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_SWITCH = 2'd2
  } wait_st_t;
endpackage

// File: rtl/osc_wait_prescaler.sv
module osc_wait_prescaler #(
  parameter int DIV_W   = 3,
  parameter int SHIFT_W = 4,
  parameter int FR_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rc_ce,
  input  logic               load,
  input  logic [DIV_W-1:0]   div_in,
  input  logic [SHIFT_W-1:0] shift,
  output logic               term
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] div_q, div_n;
  logic [PRE_W-1:0] pre_q, pre_n, dmask;
  logic [FR_W-1:0]  fr_q, fr_n, fmask;
  logic             dtick;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) dmask[i] = (i < int'(div_q));
    for (int i = 0; i < FR_W; i++)  fmask[i] = (i < int'(shift));
    dtick = rc_ce && ((pre_q & dmask) == dmask);
    term  = dtick && ((fr_q & fmask) == fmask);
    div_n = load  ? div_in : div_q;
    pre_n = rc_ce ? pre_q + PRE_W'(1) : pre_q;
    fr_n  = dtick ? fr_q + FR_W'(1) : fr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
      fr_q  <= '0;
    end else begin
      div_q <= div_n;
      pre_q <= pre_n;
      fr_q  <= fr_n;
    end
  end

  AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(div_q)); // R6
endmodule

// File: rtl/osc_wait_counter.sv
module osc_wait_counter #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [LEN_W-1:0] limit,
  output logic             hit
);
  logic [LEN_W-1:0] cnt_q, cnt_n;

  always_comb begin
    hit   = tick && (cnt_q == limit - LEN_W'(1));
    cnt_n = cnt_q;
    if (clear)     cnt_n = '0;
    else if (hit)  cnt_n = '0;
    else if (tick) cnt_n = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> cnt_q < limit); // R2
endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int SEL_W      = 3,
  parameter int DIV_W      = 3,
  parameter int BASE_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic [SEL_W-1:0] sel_wdata,
  output logic [SEL_W-1:0] sel_q,
  input  logic             ext_ce,
  input  logic             rc_ce,
  input  logic             tgt_ext,
  input  logic             wake_req,
  input  logic             switch_req,
  input  logic             stby_entry,
  input  logic [DIV_W-1:0] div_sel,
  output logic             done,
  output logic             clk_grant
);
  import osc_wait_pkg::*;

  localparam int MAX_SHIFT = BASE_SHIFT + (1 << SEL_W) - 1;
  localparam int LEN_W     = MAX_SHIFT + 1;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  wait_st_t         st_q, st_n;
  logic [SEL_W-1:0] sel_n, selh_q, selh_n;
  logic             tgt_q, tgt_n, seen_q, seen_n;
  logic             done_n, grant_n, fin;
  logic             req, wk_tick, wk_hit, term;
  logic [SHIFT_W-1:0] shift;
  logic [LEN_W-1:0]   limit;

  assign req   = wake_req | switch_req;
  assign shift = SHIFT_W'(selh_q) + SHIFT_W'(BASE_SHIFT);
  assign limit = LEN_W'(1) << shift;

  osc_wait_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(req | stby_entry),
    .tick(wk_tick), .limit(limit), .hit(wk_hit)
  );

  osc_wait_prescaler #(.DIV_W(DIV_W), .SHIFT_W(SHIFT_W), .FR_W(MAX_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .rc_ce(rc_ce), .load(switch_req),
    .div_in(div_sel), .shift(shift), .term(term)
  );

  always_comb begin
    wk_tick = (st_q == ST_WAKE) && (tgt_q ? ext_ce : rc_ce);
    sel_n   = sel_we ? sel_wdata : sel_q;
    selh_n  = req ? sel_q : selh_q;
    tgt_n   = wake_req ? tgt_ext : tgt_q;
    st_n    = st_q;
    seen_n  = seen_q;
    fin     = 1'b0;
    if (stby_entry) begin
      st_n = ST_IDLE;
    end else if (wake_req) begin
      st_n = ST_WAKE;
    end else if (switch_req) begin
      st_n   = ST_SWITCH;
      seen_n = 1'b0;
    end else begin
      case (st_q)
        ST_WAKE: if (wk_hit) begin
          fin  = 1'b1;
          st_n = ST_IDLE;
        end
        ST_SWITCH: if (term) begin
          if (seen_q) begin
            fin  = 1'b1;
            st_n = ST_IDLE;
          end else begin
            seen_n = 1'b1;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
    done_n  = fin;
    grant_n = clk_grant;
    if (req || stby_entry) grant_n = 1'b0;
    else if (done)         grant_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sel_q     <= '0;
      selh_q    <= '0;
      tgt_q     <= 1'b0;
      seen_q    <= 1'b0;
      done      <= 1'b0;
      clk_grant <= 1'b0;
    end else begin
      st_q      <= st_n;
      sel_q     <= sel_n;
      selh_q    <= selh_n;
      tgt_q     <= tgt_n;
      seen_q    <= seen_n;
      done      <= done_n;
      clk_grant <= grant_n;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_GRANT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req && !stby_entry) |=> clk_grant); // R7
  AST_REQ_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (req || stby_entry) |=> !clk_grant); // R9
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_q == $past(sel_wdata)); // R1
  AST_NO_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req || stby_entry) |=> !done); // R8
endmodule

// File: tb/tb_osc_settle_timer.sv
module tb_osc_settle_timer;
  logic       clk, rst_n;
  logic       sel_we, ext_ce, rc_ce, tgt_ext, wake_req, switch_req, stby_entry;
  logic [2:0] sel_wdata, sel_q, div_sel;
  logic       done, clk_grant;

  int cyc = 0, checks = 0, fails = 0;
  int lo_q[$], hi_q[$];
  string tag_q[$];

  osc_settle_timer dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata), .sel_q(sel_q),
    .ext_ce(ext_ce), .rc_ce(rc_ce), .tgt_ext(tgt_ext), .wake_req(wake_req),
    .switch_req(switch_req), .stby_entry(stby_entry), .div_sel(div_sel),
    .done(done), .clk_grant(clk_grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // monitor: pops expected done windows and compares
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (lo_q.size() == 0) begin
        chk(1'b0, "R8/R9 unexpected done", cyc, -1);
      end else begin
        int lo, hi;
        string t;
        lo = lo_q.pop_front(); hi = hi_q.pop_front(); t = tag_q.pop_front();
        chk(cyc >= lo && cyc <= hi, t, cyc, lo);
      end
    end
  end

  task automatic wait_grant(input string t);
    while (lo_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(clk_grant === 1'b1, {t, " R7 grant"}, clk_grant, 1);
    chk(done === 1'b0, {t, " R7 done width"}, done, 0);
  endtask

  task automatic write_sel(input logic [2:0] v);
    @(negedge clk);
    sel_we = 1'b1; sel_wdata = v;
    @(negedge clk);
    sel_we = 1'b0;
    chk(sel_q === v, "R1 sel readback", sel_q, v);
  endtask

  // wake: wrong source held high, right source pulses every other cycle
  task automatic do_wake(input bit tgt, input logic [2:0] s, input string t, input bit push);
    int n;
    n = 1 << (s + 3);
    @(negedge clk);
    tgt_ext = tgt; wake_req = 1'b1;
    ext_ce = 1'b1; rc_ce = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    for (int k = 1; k <= n; k++) begin
      ext_ce = 1'b1; rc_ce = 1'b1;
      if (k == n && push) begin
        lo_q.push_back(cyc + 1); hi_q.push_back(cyc + 1); tag_q.push_back(t);
      end
      if (!push && k == 5) break;
      @(negedge clk);
      if (tgt) ext_ce = 1'b0; else rc_ce = 1'b0;
      @(negedge clk);
    end
    ext_ce = 1'b0; rc_ce = 1'b0;
  endtask

  task automatic do_switch(input logic [2:0] s, input logic [2:0] d, input bit bump, input string t);
    int n, dv, e;
    n = 1 << (s + 3); dv = 1 << d;
    @(negedge clk);
    switch_req = 1'b1; div_sel = d; rc_ce = 1'b1; ext_ce = 1'b0;
    e = cyc + 1;
    lo_q.push_back(e + n * dv); hi_q.push_back(e + 2 * n * dv); tag_q.push_back(t);
    @(negedge clk);
    switch_req = 1'b0;
    if (bump) begin
      @(negedge clk);
      div_sel = 3'd3;
    end
    while (lo_q.size() != 0) @(negedge clk);
    rc_ce = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sel_we = 0; sel_wdata = 0; ext_ce = 0; rc_ce = 0; tgt_ext = 0;
    wake_req = 0; switch_req = 0; stby_entry = 0; div_sel = 0;
    repeat (3) @(negedge clk);
    chk(sel_q === 3'd0, "R1 reset code", sel_q, 0);
    chk(done === 1'b0, "R10 reset done", done, 0);
    chk(clk_grant === 1'b0, "R10 reset grant", clk_grant, 0);
    rst_n = 1'b1;
    @(negedge clk);

    do_wake(1'b1, 3'd0, "R2 R3 wake ext n=8", 1'b1);
    wait_grant("wake ext");
    @(negedge clk); stby_entry = 1'b1;
    @(negedge clk); stby_entry = 1'b0;
    chk(clk_grant === 1'b0, "R9 standby clears grant", clk_grant, 0);

    write_sel(3'd2);
    div_sel = 3'd7;
    do_wake(1'b0, 3'd2, "R3 R4 wake rc n=32 div7", 1'b1);
    wait_grant("wake rc");

    write_sel(3'd1);
    do_wake(1'b1, 3'd1, "R8 abandoned", 1'b0);
    do_wake(1'b1, 3'd1, "R8 restart wake n=16", 1'b1);
    wait_grant("restart");

    do_wake(1'b0, 3'd1, "R9 abort", 1'b0);
    @(negedge clk); stby_entry = 1'b1;
    @(negedge clk); stby_entry = 1'b0;
    for (int k = 0; k < 40; k++) begin
      rc_ce = k[0];
      @(negedge clk);
    end
    rc_ce = 1'b0;
    chk(clk_grant === 1'b0, "R9 abort no grant", clk_grant, 0);

    write_sel(3'd0);
    do_switch(3'd0, 3'd0, 1'b0, "R5 switch n=8 d=1");
    wait_grant("switch a");
    write_sel(3'd1);
    do_switch(3'd1, 3'd2, 1'b0, "R5 switch n=16 d=4");
    wait_grant("switch b");
    write_sel(3'd0);
    do_switch(3'd0, 3'd1, 1'b1, "R6 switch div held d=2");
    wait_grant("switch c");

    write_sel(3'd7);
    do_wake(1'b0, 3'd7, "R1 R2 wake n=1024", 1'b1);
    wait_grant("wake long");

    repeat (4) @(negedge clk);
    chk(lo_q.size() == 0, "R2 pending done", lo_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule